// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block collects interrupt vectors from on-chip sources and stores each one as a 128-bit record in a circular ring held in system memory. A host reads the records and tells the block how far it has read by writing a read pointer. Both pointers count bytes. The block raises an interrupt line while unread records remain. It records a sticky overflow when a new record lands on the slot the host is about to read. It can also copy its write pointer to a memory location of the host's choosing after every update.

Incoming vectors wait in a small FIFO. A sequencer emits each record as four 32-bit word writes on a valid/ready memory port, lowest word first, and then emits an optional writeback word. Software configures the block through a flat register file. Reg address 0 is control. Address 1 is the ring base, whose bits [7:0] are forced to zero. Address 2 is the read pointer. Address 3 is the write pointer, which is read-only. Addresses 4 and 5 are the low and high writeback address. Address 6 is status, with bit 0 for busy and bit 1 for the interrupt level.

Top module: `ivr_writer`

## Requirements
- R1: `irq_o` is low whenever the read pointer equals the write pointer and the overflow flag is clear. It goes high on the edge that commits a record while control bit 9 (interrupt enable) is set.
- R2: The write pointer starts at 0 and advances by 16 on each commit, modulo a ring of 4<<S bytes. S is the 5-bit size field at control bits [5:1].
- R3: Record word k (k = 0..3) is written to base + wptr + 4k. Word 0 carries the source id in [7:0]. Word 1 carries the 28-bit source data in [27:0]. Word 2 carries the ring id in [7:0], the VM id in [15:8] and the address-space id in [31:16]. Every other bit is zero.
- R4: A commit that makes the new write pointer equal the read pointer sets a sticky overflow flag, but only while control bit 6 is set. The flag reads back as bit 0 of the write-pointer register.
- R5: A register write to control with bit 7 set clears the overflow flag. Bit 7 itself is not stored.
- R6: While control bit 8 is set, each commit is followed by one memory write to address {hi[7:0], lo[31:0]} of the write-pointer readback value.
- R7: While control bit 0 (ring enable) is 0, both pointers read 0, host read-pointer writes are ignored, and no new record write starts.
- R8: A read-pointer write leaves the interrupt pending only if control bit 10 (rearm) is set and the new read pointer differs from the write pointer. Otherwise it drops the interrupt.
- R9: Status bit 0 is high while the FIFO holds a vector or a record write is in progress.
- R10: `src_ready` is low exactly when the FIFO holds DEPTH vectors.
- R11: While `mem_valid` is high and `mem_ready` is low, the address and data are held and the write pointer does not move.
- R12: With `mem_ready` held high, the write pointer and interrupt update on the fifth rising edge after the edge that accepts a vector into an empty, idle block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Source offers a vector |
| src_ready | output | 1 | FIFO can take a vector |
| src_id | input | 8 | Source identifier |
| src_data | input | 28 | Source payload |
| src_ring | input | 8 | Ring identifier |
| src_vmid | input | 8 | VM identifier |
| src_pasid | input | 16 | Process address-space identifier |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_valid | output | 1 | Memory word write request |
| mem_ready | input | 1 | Memory accepts the word |
| mem_addr | output | 40 | Byte address of the word |
| mem_data | output | 32 | Word to write |
| irq_o | output | 1 | Interrupt level |

## Verification
A vector accepted on edge e0 is offered as word 0 after e1. Its words are accepted on e2 through e5, and the commit lands on e5. The writeback word follows on e6. A register write takes effect on the next edge, so its effect on `irq_o` and the readback shows at the following sample. The bench reads the write pointer on each of the five falling edges after acceptance and expects the old value four times and the new value on the fifth. Every other result is checked only after the bench has waited for status busy to fall and for its expected-write queue to drain. Memory words are compared one handshake at a time, in order, against the queue filled by the driver.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

  localparam int unsigned ENTRY_W = 128;

  typedef struct packed {
    logic [15:0] pasid;
    logic [7:0]  vmid;
    logic [7:0]  ring;
    logic [27:0] data;
    logic [7:0]  id;
  } ivr_vec_t;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_W0, SEQ_W1, SEQ_W2, SEQ_W3, SEQ_WB
  } seq_state_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_RPTR = 3'd2;
  localparam logic [2:0] RA_WPTR = 3'd3;
  localparam logic [2:0] RA_WBLO = 3'd4;
  localparam logic [2:0] RA_WBHI = 3'd5;
  localparam logic [2:0] RA_STAT = 3'd6;

  localparam int CB_EN     = 0;
  localparam int CB_SZ_LSB = 1;
  localparam int CB_DET    = 6;
  localparam int CB_CLR    = 7;
  localparam int CB_WB     = 8;
  localparam int CB_IRQ    = 9;
  localparam int CB_REARM  = 10;

  function automatic logic [ENTRY_W-1:0] pack_entry(ivr_vec_t v);
    logic [ENTRY_W-1:0] e;
    e         = '0;
    e[7:0]    = v.id;
    e[59:32]  = v.data;
    e[71:64]  = v.ring;
    e[79:72]  = v.vmid;
    e[95:80]  = v.pasid;
    return e;
  endfunction

endpackage

// File: rtl/ivr_fifo.sv
module ivr_fifo #(
  parameter int W     = 68,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slot_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          ptr_en;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && (wr_q == AW'(i))) slot_q[i] <= din;
      end
    end
  endgenerate

  always_comb begin
    wr_d   = push ? bump(wr_q) : wr_q;
    rd_d   = pop  ? bump(rd_q) : rd_q;
    cnt_d  = cnt_q + (AW+1)'(push) - (AW+1)'(pop);
    ptr_en = push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout  = slot_q[rd_q];
  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr #(
  parameter int PTR_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_en,
  input  logic [PTR_W-1:0] mask,
  input  logic             det_en,
  input  logic             ovf_clr,
  input  logic             rearm_en,
  input  logic             rptr_we,
  input  logic [PTR_W-1:0] rptr_wdata,
  input  logic             commit,
  output logic [PTR_W-1:0] wptr_q,
  output logic [PTR_W-1:0] rptr_q,
  output logic             ovf_q,
  output logic             pend_q
);
  localparam logic [PTR_W-1:0] ALIGN = {{(PTR_W-4){1'b1}}, 4'b0000};
  localparam logic [PTR_W-1:0] STEP  = PTR_W'(16);

  logic [PTR_W-1:0] wptr_d, rptr_d, nxt_wptr;
  logic             ovf_d, pend_d, ld;

  always_comb begin
    nxt_wptr = (wptr_q + STEP) & mask;
    wptr_d   = wptr_q;
    rptr_d   = rptr_q;
    ovf_d    = ovf_q & ~ovf_clr;
    pend_d   = pend_q;
    if (rptr_we) begin
      rptr_d = rptr_wdata & mask & ALIGN;
      pend_d = rearm_en && (rptr_d != wptr_q);
    end
    if (commit) begin
      wptr_d = nxt_wptr;
      pend_d = 1'b1;
      if (det_en && (nxt_wptr == rptr_d)) ovf_d = 1'b1;
    end
    if (!ring_en) begin
      wptr_d = '0;
      rptr_d = '0;
      ovf_d  = 1'b0;
      pend_d = 1'b0;
    end
    ld = rptr_we | commit | ovf_clr | ~ring_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (ld) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      ovf_q  <= ovf_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ring_en,
  input  logic               have_vec,
  input  logic               wb_en,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [31:0]        ring_base,
  input  logic [PTR_W-1:0]   wptr,
  input  logic               ovf,
  input  logic [39:0]        wb_addr,
  input  logic               mem_ready,
  output logic               mem_valid,
  output logic [39:0]        mem_addr,
  output logic [31:0]        mem_data,
  output logic               commit,
  output logic               idle
);
  seq_state_e  state_q, state_d;
  logic [1:0]  word_sel;
  logic [31:0] ring_addr, wb_word;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (ring_en && have_vec) state_d = SEQ_W0;
      SEQ_W0:   if (mem_ready) state_d = SEQ_W1;
      SEQ_W1:   if (mem_ready) state_d = SEQ_W2;
      SEQ_W2:   if (mem_ready) state_d = SEQ_W3;
      SEQ_W3:   if (mem_ready) state_d = wb_en ? SEQ_WB : SEQ_IDLE;
      SEQ_WB:   if (mem_ready) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      SEQ_W1:  word_sel = 2'd1;
      SEQ_W2:  word_sel = 2'd2;
      SEQ_W3:  word_sel = 2'd3;
      default: word_sel = 2'd0;
    endcase
    ring_addr = ring_base + 32'(wptr) + {28'd0, word_sel, 2'b00};
    wb_word   = {{(33-PTR_W){1'b0}}, wptr[PTR_W-1:1], ovf};
    mem_valid = (state_q != SEQ_IDLE);
    commit    = (state_q == SEQ_W3) && mem_ready;
    idle      = (state_q == SEQ_IDLE);
    if (state_q == SEQ_WB) begin
      mem_addr = wb_addr;
      mem_data = wb_word;
    end else begin
      mem_addr = {8'h00, ring_addr};
      mem_data = entry[32*word_sel +: 32];
    end
  end
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18,
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_valid,
  output logic        src_ready,
  input  logic [7:0]  src_id,
  input  logic [27:0] src_data,
  input  logic [7:0]  src_ring,
  input  logic [7:0]  src_vmid,
  input  logic [15:0] src_pasid,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [39:0] mem_addr,
  output logic [31:0] mem_data,
  output logic        irq_o
);
  localparam int VEC_W = $bits(ivr_vec_t);

  logic             ring_en_q, det_q, wb_en_q, irq_en_q, rearm_q;
  logic [4:0]       sz_q;
  logic [23:0]      base_q;
  logic [31:0]      wblo_q;
  logic [7:0]       wbhi_q;
  logic             ctrl_we, base_we, wblo_we, wbhi_we, rptr_we, ovf_clr;
  logic [PTR_W-1:0] mask, wptr_q, rptr_q;
  logic [5:0]       shamt;
  logic             ovf_q, pend_q, commit, seq_idle, busy;
  logic             f_full, f_empty, f_push;
  ivr_vec_t         in_vec, head_vec;
  logic [VEC_W-1:0] head_raw;

  always_comb begin
    ctrl_we = reg_we && (reg_addr == RA_CTRL);
    base_we = reg_we && (reg_addr == RA_BASE);
    wblo_we = reg_we && (reg_addr == RA_WBLO);
    wbhi_we = reg_we && (reg_addr == RA_WBHI);
    rptr_we = reg_we && (reg_addr == RA_RPTR) && ring_en_q;
    ovf_clr = ctrl_we && reg_wdata[CB_CLR];
    shamt   = {1'b0, sz_q} + 6'd2;
    mask    = (PTR_W'(1) << shamt) - PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_en_q <= 1'b0;
      sz_q      <= '0;
      det_q     <= 1'b0;
      wb_en_q   <= 1'b0;
      irq_en_q  <= 1'b0;
      rearm_q   <= 1'b0;
    end else if (ctrl_we) begin
      ring_en_q <= reg_wdata[CB_EN];
      sz_q      <= reg_wdata[CB_SZ_LSB +: 5];
      det_q     <= reg_wdata[CB_DET];
      wb_en_q   <= reg_wdata[CB_WB];
      irq_en_q  <= reg_wdata[CB_IRQ];
      rearm_q   <= reg_wdata[CB_REARM];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_we) base_q <= reg_wdata[31:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wblo_q <= '0;
    else if (wblo_we) wblo_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wbhi_q <= '0;
    else if (wbhi_we) wbhi_q <= reg_wdata[7:0];
  end

  assign in_vec = '{pasid: src_pasid, vmid: src_vmid, ring: src_ring,
                    data: src_data, id: src_id};
  assign f_push    = src_valid && !f_full;
  assign src_ready = !f_full;
  assign head_vec  = ivr_vec_t'(head_raw);

  ivr_fifo #(.W(VEC_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (f_push),
    .din   (in_vec),
    .pop   (commit),
    .dout  (head_raw),
    .full  (f_full),
    .empty (f_empty)
  );

  ivr_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_en    (ring_en_q),
    .mask       (mask),
    .det_en     (det_q),
    .ovf_clr    (ovf_clr),
    .rearm_en   (rearm_q),
    .rptr_we    (rptr_we),
    .rptr_wdata (reg_wdata[PTR_W-1:0]),
    .commit     (commit),
    .wptr_q     (wptr_q),
    .rptr_q     (rptr_q),
    .ovf_q      (ovf_q),
    .pend_q     (pend_q)
  );

  ivr_seq #(.PTR_W(PTR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_en   (ring_en_q),
    .have_vec  (!f_empty),
    .wb_en     (wb_en_q),
    .entry     (pack_entry(head_vec)),
    .ring_base ({base_q, 8'h00}),
    .wptr      (wptr_q),
    .ovf       (ovf_q),
    .wb_addr   ({wbhi_q, wblo_q}),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .commit    (commit),
    .idle      (seq_idle)
  );

  assign busy  = !f_empty || !seq_idle;
  assign irq_o = pend_q && irq_en_q && ((rptr_q != wptr_q) || ovf_q);

  always_comb begin
    unique case (reg_addr)
      RA_CTRL: reg_rdata = {21'd0, rearm_q, irq_en_q, wb_en_q, 1'b0, det_q,
                            sz_q, ring_en_q};
      RA_BASE: reg_rdata = {base_q, 8'h00};
      RA_RPTR: reg_rdata = 32'(rptr_q);
      RA_WPTR: reg_rdata = {{(33-PTR_W){1'b0}}, wptr_q[PTR_W-1:1], ovf_q};
      RA_WBLO: reg_rdata = wblo_q;
      RA_WBHI: reg_rdata = {24'd0, wbhi_q};
      RA_STAT: reg_rdata = {30'd0, irq_o, busy};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ivr_writer_chk.sv
module ivr_writer_chk #(
  parameter int PTR_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic [PTR_W-1:0] wptr_q,
  input logic [PTR_W-1:0] rptr_q,
  input logic             ovf_q,
  input logic             ovf_clr,
  input logic             ring_en_q,
  input logic             commit,
  input logic             busy,
  input logic             src_ready,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [39:0]      mem_addr,
  input logic [31:0]      mem_data
);
  assert_idle_no_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((rptr_q == wptr_q) && !ovf_q) |-> !irq_o);

  assert_wptr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (wptr_q[3:0] == 4'd0));

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr && ring_en_q) |=> ovf_q);

  assert_disabled_ptrs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_en_q |=> ((wptr_q == '0) && (rptr_q == '0) && !ovf_q));

  assert_disabled_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ring_en_q && !mem_valid) |=> !mem_valid);

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  assert_full_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !src_ready |-> busy);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(wptr_q)));
endmodule

bind ivr_writer ivr_writer_chk #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .wptr_q    (wptr_q),
  .rptr_q    (rptr_q),
  .ovf_q     (ovf_q),
  .ovf_clr   (ovf_clr),
  .ring_en_q (ring_en_q),
  .commit    (commit),
  .busy      (busy),
  .src_ready (src_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data)
);

// File: tb/tb_ivr_writer.sv
module tb_ivr_writer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        src_valid;
  logic        src_ready;
  logic [7:0]  src_id;
  logic [27:0] src_data;
  logic [7:0]  src_ring;
  logic [7:0]  src_vmid;
  logic [15:0] src_pasid;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_valid;
  logic        mem_ready;
  logic [39:0] mem_addr;
  logic [31:0] mem_data;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  logic [71:0] sb[$];

  int m_wptr, m_rptr, m_mask;
  bit m_ovf, m_det, m_wb;
  logic [31:0] m_base;
  logic [39:0] m_wba;

  always #4 clk = ~clk;

  ivr_writer dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && mem_valid && mem_ready) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: unexpected write actual=%0h expected=none", {mem_addr, mem_data});
      end else begin
        chk("R3/R6 memory word", {mem_addr, mem_data}, sb.pop_front());
      end
    end
  end

  function automatic logic [31:0] ctrl(bit en, int sz, bit det, bit wb, bit ie, bit ra, bit clr);
    return 32'(en) | (32'(sz) << 1) | (32'(det) << 6) | (32'(clr) << 7)
         | (32'(wb) << 8) | (32'(ie) << 9) | (32'(ra) << 10);
  endfunction

  task automatic exp_entry(int k);
    logic [31:0] a;
    logic [31:0] w [4];
    int nxt;
    a = m_base + 32'(m_wptr);
    w[0] = {24'd0, 8'h10 + 8'(k)};
    w[1] = {4'd0, 28'hABC0000 + 28'(k)};
    w[2] = {16'h1230 + 16'(k), 8'h40 + 8'(k), 8'(k)};
    w[3] = 32'd0;
    for (int i = 0; i < 4; i++) sb.push_back({8'h00, a + 32'(4*i), w[i]});
    nxt = (m_wptr + 16) & m_mask;
    if (m_det && nxt == m_rptr) m_ovf = 1;
    m_wptr = nxt;
    if (m_wb) sb.push_back({m_wba, 32'(m_wptr) | 32'(m_ovf)});
  endtask

  task automatic push(int k);
    @(negedge clk);
    src_valid = 1'b1;
    src_id = 8'h10 + 8'(k); src_data = 28'hABC0000 + 28'(k);
    src_ring = 8'(k); src_vmid = 8'h40 + 8'(k); src_pasid = 16'h1230 + 16'(k);
    while (!src_ready) @(negedge clk);
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      rd(3'd6, d);
      if (d[0] == 1'b0 && sb.size() == 0) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; src_valid = 0; src_id = 0; src_data = 0; src_ring = 0;
    src_vmid = 0; src_pasid = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    mem_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd3, d); chk("R2 reset wptr", d, 0);
    rd(3'd6, d); chk("R9 reset status", d, 0);
    chk("R1 reset irq", irq_o, 0);
    chk("R10 reset ready", src_ready, 1);
    chk("R7 reset mem_valid", mem_valid, 0);

    m_base = 32'h4000; m_mask = 63; m_wptr = 0; m_rptr = 0;
    m_ovf = 0; m_det = 1; m_wb = 0; m_wba = 40'h12_0000_1000;
    wr(3'd1, 32'h4000);
    wr(3'd0, ctrl(1, 4, 1, 0, 1, 0, 0));

    exp_entry(0); push(0);
    for (int i = 0; i < 4; i++) begin rd(3'd3, d); chk("R12 before commit", d, 0); end
    rd(3'd3, d); chk("R12 commit edge", d, 16);
    chk("R1 irq after commit", irq_o, 1);
    wait_idle();
    rd(3'd6, d); chk("R9 idle status", d, 32'h2);

    wr(3'd2, 16); #2 chk("R1 irq equal ptrs", irq_o, 0);
    m_rptr = 16;

    exp_entry(1); push(1); exp_entry(2); push(2); exp_entry(3); push(3);
    wait_idle();
    rd(3'd3, d); chk("R2 wrap", d, 0);

    exp_entry(4); push(4); wait_idle();
    rd(3'd3, d); chk("R4 overflow flag", d, 17);
    chk("R4 irq with overflow", irq_o, 1);

    wr(3'd0, ctrl(1, 4, 1, 0, 1, 0, 1)); m_ovf = 0;
    rd(3'd3, d); chk("R5 clear", d, 16);
    chk("R1 irq after clear", irq_o, 0);

    wr(3'd4, 32'h1000); wr(3'd5, 32'h12);
    wr(3'd0, ctrl(1, 4, 1, 1, 1, 0, 0)); m_wb = 1;
    exp_entry(5); push(5); wait_idle();
    rd(3'd3, d); chk("R6 wptr after writeback", d, 32);

    wr(3'd2, 16); #2 chk("R8 no rearm", irq_o, 0);
    wr(3'd0, ctrl(1, 4, 1, 1, 1, 1, 0));
    @(negedge clk); mem_ready = 0;
    exp_entry(6); push(6);
    repeat (6) @(negedge clk);
    #2 chk("R11 held valid", mem_valid, 1);
    rd(3'd3, d); chk("R11 no advance", d, 32);
    rd(3'd6, d); chk("R9 busy in stall", d[0], 1);
    @(negedge clk); mem_ready = 1;
    wait_idle();
    rd(3'd3, d); chk("R2 after stall", d, 48);
    wr(3'd2, 32); #2 chk("R8 rearm lagging", irq_o, 1);
    wr(3'd2, 48); #2 chk("R8 rearm caught up", irq_o, 0);

    wr(3'd0, ctrl(0, 4, 1, 1, 1, 1, 0));
    rd(3'd3, d); chk("R7 wptr zero", d, 0);
    wr(3'd2, 32);
    rd(3'd2, d); chk("R7 rptr ignored", d, 0);
    for (int k = 7; k < 11; k++) push(k);
    #2 chk("R10 full", src_ready, 0);
    rd(3'd6, d); chk("R9 busy while disabled", d[0], 1);
    repeat (10) @(negedge clk);
    #2 chk("R7 no write", mem_valid, 0);

    m_wptr = 0; m_rptr = 0; m_ovf = 0;
    for (int k = 7; k < 11; k++) exp_entry(k);
    wr(3'd0, ctrl(1, 4, 1, 1, 1, 1, 0));
    wait_idle();
    rd(3'd3, d); chk("R4 wrap onto rptr", d, 1);
    chk("R10 ready again", src_ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule